// File: doc/BRIEF.md
# Memory-Mapped Disk and Printer Control Decoder

This block sits on a host's 16-bit memory bus and carves the bottom 16 KiB (0x0000–0x3FFF) into three regions while the add-on interface is paged in: an expansion ROM, a 4 KiB work RAM, and a small register block. The register block controls a floppy disk controller, a drive control latch and a parallel printer. All of these are reached through memory addresses rather than I/O ports. The host selects a function with address bits A3 and A2.

The floppy controller gets a chip select and its two register address bits. The drive control latch holds the one-hot drive selects, the side select and the motor line. A printer byte is built up one bit at a time: each write shifts data bit D7 into an 8-bit register. A read of the strobe address fires a timed active-low strobe pulse toward the printer. The block also drives A14 on the pass-through connector high while it is paged in, so downstream devices do not decode the same range.

Top module: `mmio_disk_decoder`

## Requirements
- R1: A chip select or register access can occur only when all of these hold: mreq_n low, A15 and A14 low, romcs_in_n high, and paged_in high. At most one of rom_cs_n, ram_cs_n and fdc_cs_n is low at any time.
- R2: Inside the active window, the regions are selected as follows:
  - A13=0 selects the ROM (rom_cs_n low).
  - A13=1 with A12=1 selects the RAM (ram_cs_n low).
  - A13=1 with A12=0 selects the register block.
- R3: a14_out equals A14 OR paged_in.
- R4: In the register block, A2=0 drives fdc_cs_n low, and fdc_addr equals {A1,A0}.
- R5: A read in the register block with A3=0 and A2=1 has these effects:
  - data_oe goes high.
  - data_out bit 5 equals prn_busy (1 = busy), and all other bits read 1.
  
  data_oe is low for every other bus state.
- R6: The start of each write access in the register block with A3=0 and A2=1 shifts D7 into bit 0 of prn_byte. The older bits move one place toward bit 7. prn_sclk pulses high for one cycle. The other data bits are ignored.
- R7: The start of a read access in the register block with A3=1 and A2=1 has these effects:
  - prn_strobe_n goes low from the next clock edge for STROBE_CYCLES cycles (default 4).
  - A new such read during the pulse restarts the full count.
- R8: The start of a write access in the register block with A3=1 and A2=1 loads the drive control latch:
  - drive_sel takes D3..D0 (one bit per drive 0–3).
  - side_sel takes D4 (0 = first side, 1 = second side).
  - motor_on takes D5.
  
  Reset clears the latch to all zeros.
- R9: Only A3..A0 are decoded inside the register block, so every function repeats through 0x2000–0x2FFF. For example, 0x2FFC behaves like 0x200C.
- R10: Accesses made while paged out, or outside the window, leave the latch, prn_byte and prn_strobe_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 16 | Host address bus |
| data_in | input | 8 | Host write data |
| romcs_in_n | input | 1 | Override from another device's ROM, active low |
| paged_in | input | 1 | Interface paged into the window |
| prn_busy | input | 1 | Printer busy, high when busy |
| data_out | output | 8 | Read data for the status address |
| data_oe | output | 1 | Data bus drive enable |
| rom_cs_n | output | 1 | Expansion ROM select |
| ram_cs_n | output | 1 | Work RAM select |
| fdc_cs_n | output | 1 | Floppy controller select |
| fdc_addr | output | 2 | Floppy controller register address |
| a14_out | output | 1 | A14 toward the pass-through connector |
| drive_sel | output | 4 | One-hot drive selects |
| side_sel | output | 1 | Disk side select |
| motor_on | output | 1 | Drive motor enable |
| prn_byte | output | 8 | Printer data shift register contents |
| prn_sclk | output | 1 | One-cycle shift clock pulse per data write |
| prn_strobe_n | output | 1 | Printer strobe, active low |

## Verification
The checker watches four properties on every cycle:
- the select outputs stay mutually exclusive and are all released while paged out;
- a14_out stays high whenever paged_in is high;
- data_oe appears only during a read cycle;
- the drive latch keeps its value unless a control write begins, and the strobe falls right after a strobe read starts.

Some behaviours can only be shown by the bench's directed scenarios:
- the exact width of the strobe pulse and its restart arithmetic;
- the bit order that builds a printer byte from eight writes;
- the mirrored addresses;
- the status read value with the printer busy and with it idle.

// File: rtl/mmio_disk_pkg.sv
package mmio_disk_pkg;

    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NDRIVES = 4;

    // Function codes chosen by {A3,A2} inside the register block
    typedef enum logic [1:0] {
        FN_FDC0   = 2'b00,
        FN_PRNDAT = 2'b01,
        FN_FDC1   = 2'b10,
        FN_CTRL   = 2'b11
    } blk_fn_e;

    typedef struct packed {
        logic [NDRIVES-1:0] drive;
        logic               side;
        logic               motor;
    } drv_ctl_t;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_disk_pkg::*;
(
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              romcs_in_n,
    input  logic              paged_in,
    output logic              rom_cs_n,
    output logic              ram_cs_n,
    output logic              fdc_cs_n,
    output logic [1:0]        fdc_addr,
    output logic              a14_out,
    output logic              stat_rd,
    output logic              shift_wr,
    output logic              strb_rd,
    output logic              ctl_wr
);
    logic    win;
    logic    blk;
    blk_fn_e fn;

    always_comb begin
        win = !mreq_n && (addr[15:14] == 2'b00) && romcs_in_n && paged_in;
        blk = win && addr[13] && !addr[12];
        fn  = blk_fn_e'(addr[3:2]);

        rom_cs_n = !(win && !addr[13]);
        ram_cs_n = !(win && addr[13] && addr[12]);
        fdc_cs_n = !(blk && !addr[2]);
        fdc_addr = addr[1:0];
        a14_out  = addr[14] | paged_in;

        stat_rd  = blk && (fn == FN_PRNDAT) && !rd_n;
        shift_wr = blk && (fn == FN_PRNDAT) && !wr_n;
        strb_rd  = blk && (fn == FN_CTRL)   && !rd_n;
        ctl_wr   = blk && (fn == FN_CTRL)   && !wr_n;
    end
endmodule

// File: rtl/mmio_ctrl_regs.sv
module mmio_ctrl_regs
    import mmio_disk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_wr,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] din,
    output drv_ctl_t          drv,
    output logic [DATA_W-1:0] prn_byte,
    output logic              prn_sclk
);
    typedef struct packed {
        drv_ctl_t          drv;
        logic [DATA_W-1:0] shreg;
        logic              sclk;
        logic              shift_prev;
        logic              ctl_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.shift_prev = shift_wr;
        st_d.ctl_prev   = ctl_wr;
        st_d.sclk       = 1'b0;
        if (shift_wr && !st_q.shift_prev) begin
            st_d.shreg = {st_q.shreg[DATA_W-2:0], din[DATA_W-1]};
            st_d.sclk  = 1'b1;
        end
        if (ctl_wr && !st_q.ctl_prev) begin
            st_d.drv.drive = din[NDRIVES-1:0];
            st_d.drv.side  = din[NDRIVES];
            st_d.drv.motor = din[NDRIVES+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drv      = st_q.drv;
    assign prn_byte = st_q.shreg;
    assign prn_sclk = st_q.sclk;
endmodule

// File: rtl/mmio_strobe_timer.sv
module mmio_strobe_timer #(
    parameter int unsigned STROBE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_rd,
    output logic strobe_n
);
    localparam int unsigned CNT_W = $clog2(STROBE_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strb_rd;
        if (strb_rd && !st_q.prev)
            st_d.cnt = CNT_W'(STROBE_CYCLES);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_n = (st_q.cnt == '0);
endmodule

// File: rtl/mmio_disk_decoder.sv
module mmio_disk_decoder
    import mmio_disk_pkg::*;
#(
    parameter int unsigned STROBE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [15:0]       addr,
    input  logic [7:0]        data_in,
    input  logic              romcs_in_n,
    input  logic              paged_in,
    input  logic              prn_busy,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              rom_cs_n,
    output logic              ram_cs_n,
    output logic              fdc_cs_n,
    output logic [1:0]        fdc_addr,
    output logic              a14_out,
    output logic [3:0]        drive_sel,
    output logic              side_sel,
    output logic              motor_on,
    output logic [7:0]        prn_byte,
    output logic              prn_sclk,
    output logic              prn_strobe_n
);
    localparam int unsigned BUSY_BIT = 5;

    logic     stat_rd, shift_wr, strb_rd, ctl_wr;
    drv_ctl_t drv;

    mmio_addr_decode i_dec (
        .mreq_n     (mreq_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .romcs_in_n (romcs_in_n),
        .paged_in   (paged_in),
        .rom_cs_n   (rom_cs_n),
        .ram_cs_n   (ram_cs_n),
        .fdc_cs_n   (fdc_cs_n),
        .fdc_addr   (fdc_addr),
        .a14_out    (a14_out),
        .stat_rd    (stat_rd),
        .shift_wr   (shift_wr),
        .strb_rd    (strb_rd),
        .ctl_wr     (ctl_wr)
    );

    mmio_ctrl_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_wr (shift_wr),
        .ctl_wr   (ctl_wr),
        .din      (data_in),
        .drv      (drv),
        .prn_byte (prn_byte),
        .prn_sclk (prn_sclk)
    );

    mmio_strobe_timer #(.STROBE_CYCLES(STROBE_CYCLES)) i_strb (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_rd  (strb_rd),
        .strobe_n (prn_strobe_n)
    );

    always_comb begin
        data_out           = '1;
        data_out[BUSY_BIT] = prn_busy;
        data_oe            = stat_rd;
    end

    assign drive_sel = drv.drive;
    assign side_sel  = drv.side;
    assign motor_on  = drv.motor;
endmodule

// File: rtl/mmio_disk_decoder_chk.sv
module mmio_disk_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mreq_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic [15:0] addr,
    input logic        romcs_in_n,
    input logic        paged_in,
    input logic        data_oe,
    input logic        rom_cs_n,
    input logic        ram_cs_n,
    input logic        fdc_cs_n,
    input logic        a14_out,
    input logic [3:0]  drive_sel,
    input logic        side_sel,
    input logic        motor_on,
    input logic        prn_strobe_n
);
    logic blk_hit, ctl_hit, strb_hit;
    assign blk_hit  = !mreq_n && addr[15:12] == 4'h2 && romcs_in_n && paged_in;
    assign ctl_hit  = blk_hit && addr[3:2] == 2'b11 && !wr_n;
    assign strb_hit = blk_hit && addr[3:2] == 2'b11 && !rd_n;

    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rom_cs_n, !ram_cs_n, !fdc_cs_n}) <= 1);

    p_paged_out_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !paged_in |-> (rom_cs_n && ram_cs_n && fdc_cs_n));

    p_a14_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        paged_in |-> a14_out);

    p_oe_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!rd_n && !mreq_n));

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hit |=> $stable({drive_sel, side_sel, motor_on}));

    p_strobe_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_hit && !$past(strb_hit)) |=> !prn_strobe_n);
endmodule

bind mmio_disk_decoder mmio_disk_decoder_chk i_chk (.*);

// File: tb/test_mmio_disk_decoder.sv
module test_mmio_disk_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data_in = 8'h00;
    logic        romcs_in_n = 1'b1, paged_in = 1'b1, prn_busy = 1'b0;
    logic [7:0]  data_out, prn_byte;
    logic        data_oe, rom_cs_n, ram_cs_n, fdc_cs_n, a14_out;
    logic [1:0]  fdc_addr;
    logic [3:0]  drive_sel;
    logic        side_sel, motor_on, prn_sclk, prn_strobe_n;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    mmio_disk_decoder i_mmio_disk_decoder (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; data_in = d; mreq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R8 reset latch", {side_sel, motor_on, drive_sel}, 6'h00);
        chk("R7 reset strobe", prn_strobe_n, 1'b1);
        chk("R5 reset oe", data_oe, 1'b0);
    endtask

    task automatic t_decode();
        @(negedge clk); mreq_n = 1'b0; rd_n = 1'b0;
        addr = 16'h0100; #1;
        chk("R2 rom", {rom_cs_n, ram_cs_n, fdc_cs_n}, 3'b011);
        addr = 16'h3100; #1;
        chk("R2 ram", {rom_cs_n, ram_cs_n, fdc_cs_n}, 3'b101);
        addr = 16'h2003; #1;
        chk("R4 fdc", {rom_cs_n, ram_cs_n, fdc_cs_n, fdc_addr}, 5'b11011);
        addr = 16'h2FF9; #1;
        chk("R9 fdc mirror", {fdc_cs_n, fdc_addr}, 3'b001);
        addr = 16'h4000; #1;
        chk("R1 outside window", {rom_cs_n, ram_cs_n, fdc_cs_n}, 3'b111);
        addr = 16'h0100; romcs_in_n = 1'b0; #1;
        chk("R1 override", rom_cs_n, 1'b1);
        romcs_in_n = 1'b1; paged_in = 1'b0; addr = 16'h3100; #1;
        chk("R1 paged out", {rom_cs_n, ram_cs_n, fdc_cs_n}, 3'b111);
        chk("R3 a14 paged out", a14_out, 1'b0);
        paged_in = 1'b1; #1;
        chk("R3 a14 paged in", a14_out, 1'b1);
        idle(); #1;
        chk("R1 no mreq", {rom_cs_n, ram_cs_n, fdc_cs_n}, 3'b111);
    endtask

    task automatic t_status();
        @(negedge clk); addr = 16'h2004; mreq_n = 1'b0; rd_n = 1'b0; prn_busy = 1'b1; #1;
        chk("R5 busy read", {data_oe, data_out}, 9'h1FF);
        prn_busy = 1'b0; addr = 16'h2FF4; #1;
        chk("R5 idle read mirror R9", {data_oe, data_out}, 9'h1DF);
        idle(); #1;
        chk("R5 oe off", data_oe, 1'b0);
    endtask

    task automatic t_control();
        bus_write(16'h200C, 8'h34);
        chk("R8 drive latch", {motor_on, side_sel, drive_sel}, 6'b110100);
        bus_write(16'h2FFC, 8'h01);
        chk("R9 mirror latch", {motor_on, side_sel, drive_sel}, 6'b000001);
        paged_in = 1'b0;
        bus_write(16'h200C, 8'h3F);
        paged_in = 1'b1;
        chk("R10 paged-out write ignored", {motor_on, side_sel, drive_sel}, 6'b000001);
        bus_write(16'h300C, 8'h3F);
        chk("R10 ram write ignored", {motor_on, side_sel, drive_sel}, 6'b000001);
    endtask

    task automatic t_shift();
        logic [7:0] pat = 8'hA5;
        int pulses = 0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); addr = 16'h2004; data_in = {pat[i], 7'h2A ^ 7'(i)};
            mreq_n = 1'b0; wr_n = 1'b0;
            @(negedge clk); if (prn_sclk) pulses++;
            @(negedge clk); if (prn_sclk) pulses++; idle();
            @(negedge clk); if (prn_sclk) pulses++;
        end
        chk("R6 shifted byte", prn_byte, 8'hA5);
        chk("R6 sclk pulses", pulses, 8);
        paged_in = 1'b0;
        bus_write(16'h2004, 8'h80);
        paged_in = 1'b1;
        chk("R10 shift ignored", prn_byte, 8'hA5);
    endtask

    task automatic t_strobe(input bit restart, input int exp_low, input string req);
        int lows = 0;
        @(negedge clk); addr = 16'h200C; mreq_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!prn_strobe_n) lows++;
            if (i == 1) idle();
            if (restart && i == 2) begin mreq_n = 1'b0; rd_n = 1'b0; end
            if (restart && i == 4) idle();
        end
        chk(req, lows, exp_low);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_status();
        t_control();
        t_shift();
        t_strobe(1'b0, 4, "R7 strobe width");
        t_strobe(1'b1, 7, "R7 strobe restart");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule